// File: doc/BRIEF.md
# Two-Stage DMA Channel Arbiter

This block sits between four DMA channels and a shared upstream arbiter. Each channel raises its own request line. The block picks one winner and raises a single request toward the upstream arbiter on that channel's behalf. When the upstream side grants, the block passes the grant down to the winning channel as a one-cycle pulse, or as two back-to-back pulses.

The winner is chosen in rotating order, so channels that compete receive equal service. Configuration inputs can mark one channel as favoured. That channel takes precedence whenever it requests, and its wins leave the rotation untouched.

When double grants are enabled, the winner receives a second consecutive grant pulse under three conditions:
- its next queued request has the same command type as the current one;
- the next request targets the same destination;
- the upstream free credit counters cover the cost of both requests.

In every other case the grant ends after one pulse and arbitration restarts.

Top module: `dma_chan_arb`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `up_req` is 0 and `ch_gnt` is all zeros. The rotation pointer restarts at channel 0.
- R2: In the idle arbitration state, if any `ch_req` bit is set at a clock edge, `up_req` is 1 from the next cycle on. It stays 1 until a cycle in which `up_gnt` is 1, and it is 0 in the cycle after that.
- R3: When the favoured channel does not win, the winner is the first requesting channel found at or after the rotation pointer, searching upward in index order and wrapping to 0. The pointer then moves to the index just after the winner, with channel 3 wrapping to 0.
- R4: When `cfg_hp_en` is 1 and the channel selected by `cfg_hp_sel` is requesting, that channel wins and the rotation pointer is unchanged.
- R5: In the cycle after `up_gnt` is accepted, `ch_gnt` is one-hot with bit i set for winner channel i. In all other cycles, apart from a second grant under R6, `ch_gnt` is zero and at most one bit is ever set.
- R6: A grant is held for a second consecutive cycle only if all of the following hold at the accepting edge:
  - `cfg_dbl_en` is 1;
  - the winner's `ch_nxt_vld` bit is 1;
  - the winner's next type equals its current type (field i at bits [2i+1:2i]);
  - the winner's next destination equals its current destination (field i at bits [3i+2:3i]);
  - R7 holds.
- R7: The credit condition for a second grant is `up_cmd_cred >= 2*CMD_COST` and `up_data_cred >= 2*DATA_COST`. With the defaults `CMD_COST` = 1 and `DATA_COST` = 4, that means at least 2 command credits and at least 8 data credits.
- R8: `up_gnt` has no effect outside a pending upstream request: it produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbl_en | input | 1 | Allow a second back-to-back grant |
| cfg_hp_en | input | 1 | Enable the favoured channel |
| cfg_hp_sel | input | 2 | Index of the favoured channel |
| ch_req | input | 4 | Per-channel request |
| ch_type | input | 8 | Per-channel current command type, 2 bits each |
| ch_dest | input | 12 | Per-channel current destination, 3 bits each |
| ch_nxt_vld | input | 4 | Per-channel next request ready |
| ch_nxt_type | input | 8 | Per-channel next command type |
| ch_nxt_dest | input | 12 | Per-channel next destination |
| up_cmd_cred | input | 5 | Free upstream command credits |
| up_data_cred | input | 5 | Free upstream data credits |
| up_gnt | input | 1 | Grant from the upstream arbiter |
| up_req | output | 1 | Request to the upstream arbiter |
| ch_gnt | output | 4 | Per-channel grant pulse |

## Verification
The bench stresses the wrap of the rotation pointer and the favoured channel competing against the rotation. A design that advanced the pointer on a favoured win would skip a channel's turn. One that wrapped the pointer wrongly would starve channel 0 or channel 3.

For double grants, the bench varies one qualifying condition at a time and holds the credit levels one below and exactly at the limits. An off-by-one in the credit compare, or a missing type or destination match, then shows up as a spurious or missing second grant pulse. A stray `up_gnt` outside a pending request must produce no grant.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic [1:0] {
    ST_ARB  = 2'd0,
    ST_REQ  = 2'd1,
    ST_GNT1 = 2'd2,
    ST_GNT2 = 2'd3
  } dca_state_t;
endpackage

// File: rtl/dca_rr_pick.sv
module dca_rr_pick #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  ptr,
  input  logic              hp_en,
  input  logic [IDX_W-1:0]  hp_sel,
  output logic              any,
  output logic              hp_win,
  output logic [IDX_W-1:0]  win
);
  logic [IDX_W-1:0] rr_win;

  always_comb begin
    rr_win = ptr;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NUM_CH) j = j - NUM_CH;
      if (req[j]) rr_win = IDX_W'(j);
    end
  end

  assign any    = |req;
  assign hp_win = hp_en && req[hp_sel];
  assign win    = hp_win ? hp_sel : rr_win;
endmodule

// File: rtl/dca_pair_check.sv
module dca_pair_check #(
  parameter int NUM_CH    = 4,
  parameter int TYPE_W    = 2,
  parameter int DEST_W    = 3,
  parameter int CRED_W    = 5,
  parameter int CMD_COST  = 1,
  parameter int DATA_COST = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [IDX_W-1:0]         owner,
  input  logic                     dbl_en,
  input  logic [NUM_CH-1:0]        nxt_vld,
  input  logic [NUM_CH*TYPE_W-1:0] cur_type,
  input  logic [NUM_CH*DEST_W-1:0] cur_dest,
  input  logic [NUM_CH*TYPE_W-1:0] nxt_type,
  input  logic [NUM_CH*DEST_W-1:0] nxt_dest,
  input  logic [CRED_W-1:0]        cmd_cred,
  input  logic [CRED_W-1:0]        data_cred,
  output logic                     pair_ok
);
  localparam int CMD_NEED  = 2 * CMD_COST;
  localparam int DATA_NEED = 2 * DATA_COST;

  logic [NUM_CH-1:0] same_kind;
  logic              cred_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign same_kind[g] = nxt_vld[g]
      && (cur_type[g*TYPE_W +: TYPE_W] == nxt_type[g*TYPE_W +: TYPE_W])
      && (cur_dest[g*DEST_W +: DEST_W] == nxt_dest[g*DEST_W +: DEST_W]);
  end

  assign cred_ok = (int'(cmd_cred) >= CMD_NEED) && (int'(data_cred) >= DATA_NEED);
  assign pair_ok = dbl_en && same_kind[owner] && cred_ok;
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
  parameter int NUM_CH    = 4,
  parameter int TYPE_W    = 2,
  parameter int DEST_W    = 3,
  parameter int CRED_W    = 5,
  parameter int CMD_COST  = 1,
  parameter int DATA_COST = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_dbl_en,
  input  logic                     cfg_hp_en,
  input  logic [IDX_W-1:0]         cfg_hp_sel,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*TYPE_W-1:0] ch_type,
  input  logic [NUM_CH*DEST_W-1:0] ch_dest,
  input  logic [NUM_CH-1:0]        ch_nxt_vld,
  input  logic [NUM_CH*TYPE_W-1:0] ch_nxt_type,
  input  logic [NUM_CH*DEST_W-1:0] ch_nxt_dest,
  input  logic [CRED_W-1:0]        up_cmd_cred,
  input  logic [CRED_W-1:0]        up_data_cred,
  input  logic                     up_gnt,
  output logic                     up_req,
  output logic [NUM_CH-1:0]        ch_gnt
);
  import dca_pkg::*;

  dca_state_t       st;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] owner;
  logic             dbl_q;
  logic             pick_any;
  logic             pick_hp;
  logic [IDX_W-1:0] pick_win;
  logic             pair_ok;

  dca_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req    (ch_req),
    .ptr    (ptr),
    .hp_en  (cfg_hp_en),
    .hp_sel (cfg_hp_sel),
    .any    (pick_any),
    .hp_win (pick_hp),
    .win    (pick_win)
  );

  dca_pair_check #(
    .NUM_CH(NUM_CH), .TYPE_W(TYPE_W), .DEST_W(DEST_W),
    .CRED_W(CRED_W), .CMD_COST(CMD_COST), .DATA_COST(DATA_COST)
  ) u_pair (
    .owner     (owner),
    .dbl_en    (cfg_dbl_en),
    .nxt_vld   (ch_nxt_vld),
    .cur_type  (ch_type),
    .cur_dest  (ch_dest),
    .nxt_type  (ch_nxt_type),
    .nxt_dest  (ch_nxt_dest),
    .cmd_cred  (up_cmd_cred),
    .data_cred (up_data_cred),
    .pair_ok   (pair_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_ARB;
      ptr    <= '0;
      owner  <= '0;
      dbl_q  <= 1'b0;
      up_req <= 1'b0;
      ch_gnt <= '0;
    end else begin
      unique case (st)
        ST_ARB: begin
          if (pick_any) begin
            owner  <= pick_win;
            up_req <= 1'b1;
            st     <= ST_REQ;
            if (!pick_hp) begin
              ptr <= (pick_win == IDX_W'(NUM_CH - 1)) ? '0 : pick_win + 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (up_gnt) begin
            up_req <= 1'b0;
            ch_gnt <= NUM_CH'(1) << owner;
            dbl_q  <= pair_ok;
            st     <= ST_GNT1;
          end
        end
        ST_GNT1: begin
          if (dbl_q) begin
            st <= ST_GNT2;
          end else begin
            ch_gnt <= '0;
            st     <= ST_ARB;
          end
        end
        ST_GNT2: begin
          ch_gnt <= '0;
          st     <= ST_ARB;
        end
        default: st <= ST_ARB;
      endcase
    end
  end
endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int NUM_CH    = 4,
  parameter int CRED_W    = 5,
  parameter int CMD_COST  = 1,
  parameter int DATA_COST = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_dbl_en,
  input logic [CRED_W-1:0] up_cmd_cred,
  input logic [CRED_W-1:0] up_data_cred,
  input logic              up_gnt,
  input logic              up_req,
  input logic [NUM_CH-1:0] ch_gnt
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ch_gnt == '0 && !up_req));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (up_req && !up_gnt) |=> up_req);

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (up_req && up_gnt) |=> (!up_req && ch_gnt != '0));

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_gnt));

  assert_gnt_excl_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_gnt != '0) |-> !up_req);

  assert_single_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    (up_req && up_gnt && !cfg_dbl_en) |=> ##1 (ch_gnt == '0));

  assert_credit_short_R7: assert property (@(posedge clk) disable iff (rst)
    (up_req && up_gnt && (int'(up_cmd_cred) < 2 * CMD_COST ||
                          int'(up_data_cred) < 2 * DATA_COST))
    |=> ##1 (ch_gnt == '0));

  assert_stray_gnt_R8: assert property (@(posedge clk) disable iff (rst)
    (!up_req && ch_gnt == '0) |=> (ch_gnt == '0));
endmodule

bind dma_chan_arb dca_checker #(
  .NUM_CH(NUM_CH), .CRED_W(CRED_W), .CMD_COST(CMD_COST), .DATA_COST(DATA_COST)
) u_dca_checker (
  .clk          (clk),
  .rst          (rst),
  .cfg_dbl_en   (cfg_dbl_en),
  .up_cmd_cred  (up_cmd_cred),
  .up_data_cred (up_data_cred),
  .up_gnt       (up_gnt),
  .up_req       (up_req),
  .ch_gnt       (ch_gnt)
);

// File: tb/dma_chan_arb_bench.sv
`timescale 1ns/1ps
module dma_chan_arb_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dbl_en = 1'b0;
  logic        cfg_hp_en = 1'b0;
  logic [1:0]  cfg_hp_sel = 2'd0;
  logic [3:0]  ch_req = '0;
  logic [7:0]  ch_type = '0;
  logic [11:0] ch_dest = '0;
  logic [3:0]  ch_nxt_vld = '0;
  logic [7:0]  ch_nxt_type = '0;
  logic [11:0] ch_nxt_dest = '0;
  logic [4:0]  up_cmd_cred = '0;
  logic [4:0]  up_data_cred = '0;
  logic        up_gnt = 1'b0;
  logic        up_req;
  logic [3:0]  ch_gnt;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dma_chan_arb u_dma_chan_arb (
    .clk(clk), .rst(rst), .cfg_dbl_en(cfg_dbl_en), .cfg_hp_en(cfg_hp_en),
    .cfg_hp_sel(cfg_hp_sel), .ch_req(ch_req), .ch_type(ch_type), .ch_dest(ch_dest),
    .ch_nxt_vld(ch_nxt_vld), .ch_nxt_type(ch_nxt_type), .ch_nxt_dest(ch_nxt_dest),
    .up_cmd_cred(up_cmd_cred), .up_data_cred(up_data_cred), .up_gnt(up_gnt),
    .up_req(up_req), .ch_gnt(ch_gnt)
  );

  // Behavioural reference: phase 0 idle, 1 waiting, 2 first grant, 3 second grant
  int    m_phase = 0;
  int    m_ptr = 0;
  int    m_owner = 0;
  bit    m_dbl = 0;
  bit    m_rst = 1;
  bit    exp_req = 0;
  int    exp_gnt = 0;
  string gtag = "R5";
  string ztag = "R1";
  string dtag = "R6";

  function automatic bit second_ok(int c);
    bit ty, de, cr;
    ty = ch_type[2*c +: 2] == ch_nxt_type[2*c +: 2];
    de = ch_dest[3*c +: 3] == ch_nxt_dest[3*c +: 3];
    cr = up_cmd_cred >= 2 && up_data_cred >= 8;
    return cfg_dbl_en && ch_nxt_vld[c] && ty && de && cr;
  endfunction

  function automatic bit all_but_credit(int c);
    return cfg_dbl_en && ch_nxt_vld[c] &&
           ch_type[2*c +: 2] == ch_nxt_type[2*c +: 2] &&
           ch_dest[3*c +: 3] == ch_nxt_dest[3*c +: 3];
  endfunction

  always @(posedge clk) begin
    m_rst = rst;
    if (rst) begin
      m_phase = 0; m_ptr = 0; exp_req = 0; exp_gnt = 0; ztag = "R1";
    end else begin
      ztag = (up_gnt && m_phase != 1) ? "R8" : "R5";
      case (m_phase)
        0: if (ch_req != 0) begin
          if (cfg_hp_en && ch_req[cfg_hp_sel]) begin
            m_owner = cfg_hp_sel; gtag = "R4";
          end else begin
            for (int k = 0; k < N; k++) begin
              if (ch_req[(m_ptr + k) % N]) begin
                m_owner = (m_ptr + k) % N;
                break;
              end
            end
            m_ptr = (m_owner + 1) % N;
            gtag = "R3";
          end
          exp_req = 1; m_phase = 1;
        end
        1: if (up_gnt) begin
          exp_req = 0; exp_gnt = 1 << m_owner;
          m_dbl = second_ok(m_owner);
          dtag = (all_but_credit(m_owner)) ? "R7" : "R6";
          m_phase = 2;
        end
        2: begin
          if (m_dbl) begin m_phase = 3; gtag = dtag; end
          else begin exp_gnt = 0; m_phase = 0; ztag = dtag; end
        end
        default: begin exp_gnt = 0; m_phase = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    string rtag, gt;
    rtag = m_rst ? "R1" : "R2";
    gt   = m_rst ? "R1" : (exp_gnt != 0 ? gtag : ztag);
    vectors += 2;
    if (up_req !== exp_req) begin
      miscompares++;
      $display("FAIL %s up_req actual=%0b expected=%0b t=%0t", rtag, up_req, exp_req, $time);
    end
    if (ch_gnt !== 4'(exp_gnt)) begin
      miscompares++;
      $display("FAIL %s ch_gnt actual=%b expected=%b t=%0t", gt, ch_gnt, 4'(exp_gnt), $time);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    run(4);                       // R1 reset state
    rst = 1'b0;
    up_cmd_cred = 5'd16; up_data_cred = 5'd16;
    // R3 rotation among all channels, single grants, R8 stray grant while idle
    up_gnt = 1'b1; run(3);
    ch_req = 4'b1111; run(40);
    ch_req = 4'b1010; run(20);
    // R4 favoured channel beats rotation
    cfg_hp_en = 1'b1; cfg_hp_sel = 2'd2; ch_req = 4'b1111; run(20);
    cfg_hp_sel = 2'd1; ch_req = 4'b1001; run(16);
    cfg_hp_en = 1'b0;
    // R6 double grant, one qualifying condition broken at a time
    ch_type = 8'b11_10_01_00; ch_dest = 12'o7531;
    ch_nxt_type = ch_type; ch_nxt_dest = ch_dest;
    cfg_dbl_en = 1'b1; ch_nxt_vld = 4'b1111; ch_req = 4'b1111; run(30);
    ch_nxt_type = 8'b11_10_01_01; run(20);
    ch_nxt_type = ch_type; ch_nxt_dest = 12'o7530; run(20);
    ch_nxt_dest = ch_dest; ch_nxt_vld = 4'b0101; run(20);
    ch_nxt_vld = 4'b1111;
    // R7 credit boundaries
    up_cmd_cred = 5'd1; run(16);
    up_cmd_cred = 5'd2; run(16);
    up_data_cred = 5'd7; run(16);
    up_data_cred = 5'd8; run(16);
    // slow upstream grant
    up_gnt = 1'b0; run(5); up_gnt = 1'b1; run(10);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ch_req      = lfsr[3:0];
      up_gnt      = lfsr[4] | lfsr[5];
      cfg_dbl_en  = lfsr[6] | lfsr[7];
      cfg_hp_en   = lfsr[9] & lfsr[10];
      cfg_hp_sel  = lfsr[12:11];
      ch_type     = {4{lfsr[14:13]}} ^ {6'd0, lfsr[16:15]};
      ch_nxt_type = lfsr[17] ? ch_type : ~ch_type;
      ch_dest     = {4{lfsr[2:0]}};
      ch_nxt_dest = lfsr[18] ? ch_dest : ch_dest ^ 12'o0101;
      ch_nxt_vld  = lfsr[22:19] | {3'd0, lfsr[8]};
      up_cmd_cred = {1'b0, lfsr[26:23]} % 5'd4;
      up_data_cred = 5'd5 + {2'b0, lfsr[29:27]};
      run(1);
    end
    ch_req = '0; up_gnt = 1'b0; run(4);
    finish_run();
  end
endmodule